// File: doc/BRIEF.md
# Configuration Transaction Engine

This block is a small register-triggered engine for reading and changing board configuration values. It has three bus-visible registers: a data word, a command word and a two-bit status word. Software first loads the data word, then writes the command word with its start bit set. The engine splits the command into a controller index, a function code, a site, a board position and a device number. It then carries out the command against an internal table. The table holds writable oscillator frequencies and fixed voltage readings for a motherboard site and a daughterboard site. Some commands produce single-cycle shutdown or reboot requests instead of a table access.

A read command places its result in the data word. A write command takes its value from the data word. Every launched command sets a completion flag in the status word. Commands the engine does not support also set an error flag. Commands for the display mux and the display mode are accepted and do nothing else. The register window exists only when the board identifier parameter equals 0x190. With any other identifier the window reads as zero and ignores writes.

Top module: `cfg_txn_engine`

## Requirements
- R1: After reset the data, command and status words read as zero. The six motherboard oscillator entries hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000 for devices 0 to 5. Each daughterboard oscillator entry holds its parameter reset value.
- R2: Writing the command word (offset 0xA4) stores all bits except bit 31 (start) and bits 19:18, which always read back as zero. The field layout is: bit 30 write(1)/read(0), bits 29:26 controller index, 25:20 function, 17:16 site, 15:12 position, 11:0 device.
- R3: A command word write with bit 31 set executes at the clock edge after the write edge. Until then the status word is unchanged. A command word write with bit 31 clear executes nothing.
- R4: A command whose controller index is not 0, whose position is not 0, or whose site is 2 or 3 completes with status 3 (bit 0 complete, bit 1 error). It leaves the data word and all tables unchanged.
- R5: Function 1 at site 0 reads or writes motherboard oscillator devices 0 to 5, with status 1. Device 6 or above gives status 3.
- R6: Function 1 at site 1 reads or writes daughterboard oscillator devices below the daughterboard oscillator count. Any higher device gives status 3.
- R7: Function 2 read at site 0 device 0 returns 3300000. At site 1 it returns the daughterboard voltage parameter for each device below the voltage count. Any other device, and any function 2 write, gives status 3.
- R8: A write with function 7 or 11 at site 0 device 0 completes with status 1 and changes no table and no data. The same functions at any other site or device, or as reads, give status 3.
- R9: A write with function 8 (site 0, device 0) drives the shutdown request high for exactly one cycle, in the cycle after execution. Function 9 does the same on the reboot request. Reads of these functions give status 3 and no pulse.
- R10: A direct write to the status word (offset 0xA8) stores bits 1:0 only.
- R11: Any function code other than 1, 2, 7, 8, 9 and 11 completes with status 3.
- R12: When the board identifier is not 0x190, the whole window reads zero, writes are ignored and no request pulses occur.
- R13: The data word lives at offset 0xA0. Any offset outside 0xA0, 0xA4 and 0xA8 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset for reads and writes |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for bus_addr (combinational) |
| shutdown_req | output | 1 | One-cycle shutdown request |
| reboot_req | output | 1 | One-cycle reboot request |

## Verification
A wrong decoded field or table index shows up in the status word and data word. Both can be read two clock edges after the command write. A corrupted oscillator entry stays hidden until a later read command addresses that device, so the stimulus keeps revisiting the small device range to expose stale entries within a few commands. A wrongly timed or stretched request pulse is visible at the ports in the cycle after execution and the one after it.

// File: rtl/cfg_txn_pkg.sv
package cfg_txn_pkg;

  localparam int WORD_W   = 32;
  localparam int MB_OSC_N = 6;

  localparam logic [31:0] MB_VOLT_UV = 32'd3300000;

  localparam logic [5:0] FN_OSC    = 6'd1;
  localparam logic [5:0] FN_VOLT   = 6'd2;
  localparam logic [5:0] FN_MUX    = 6'd7;
  localparam logic [5:0] FN_SHUT   = 6'd8;
  localparam logic [5:0] FN_REBOOT = 6'd9;
  localparam logic [5:0] FN_DISP   = 6'd11;

  localparam logic [1:0] SITE_MB = 2'd0;
  localparam logic [1:0] SITE_DB = 2'd1;

  // command word layout, most significant field first
  typedef struct packed {
    logic        start;
    logic        wr;
    logic [3:0]  ctl;
    logic [5:0]  func;
    logic [1:0]  rsvd;
    logic [1:0]  site;
    logic [3:0]  pos;
    logic [11:0] dev;
  } cmd_t;

  typedef enum logic [1:0] {RSRC_NONE, RSRC_OSC, RSRC_VOLT} rsrc_e;

  // reset frequency of a motherboard oscillator entry
  function automatic logic [31:0] mb_osc_reset(input int idx);
    if (idx == 0)      return 32'd50000000;
    else if (idx == 1) return 32'd23750000;
    else               return 32'd24000000;
  endfunction

  // bits kept when the command word is stored: start and 19:18 dropped
  function automatic logic [31:0] ctrl_keep(input logic [31:0] v);
    return v & ~32'h800C_0000;
  endfunction

  // status posted by a finished command
  function automatic logic [1:0] stat_word(input logic err);
    return {err, 1'b1};
  endfunction

endpackage

// File: rtl/cfg_cmd_decode.sv
module cfg_cmd_decode
  import cfg_txn_pkg::*;
#(
  parameter int DB_OSC_N   = 2,
  parameter int DB_VOLT_N  = 3,
  parameter int OSC_IDX_W  = 3,
  parameter int VOLT_IDX_W = 2
) (
  input  cmd_t                  cmd,
  output logic                  fail,
  output logic                  osc_we,
  output rsrc_e                 rsrc,
  output logic [OSC_IDX_W-1:0]  osc_idx,
  output logic [VOLT_IDX_W-1:0] volt_idx,
  output logic                  shut,
  output logic                  reboot
);

  logic base_ok, on_mb, on_db, dev0;
  logic mb_osc_hit, db_osc_hit, db_volt_hit, mb_only;
  logic unused_bits;

  assign unused_bits = ^{cmd.start, cmd.rsvd};

  assign on_mb       = (cmd.site == SITE_MB);
  assign on_db       = (cmd.site == SITE_DB);
  assign dev0        = (cmd.dev == 12'd0);
  assign base_ok     = (cmd.ctl == 4'd0) && (cmd.pos == 4'd0) && (on_mb || on_db);
  assign mb_osc_hit  = on_mb && (int'(cmd.dev) < MB_OSC_N);
  assign db_osc_hit  = on_db && (int'(cmd.dev) < DB_OSC_N);
  assign db_volt_hit = on_db && (int'(cmd.dev) < DB_VOLT_N);
  assign mb_only     = cmd.wr && on_mb && dev0;

  assign osc_idx  = on_db ? OSC_IDX_W'(MB_OSC_N + int'(cmd.dev)) : OSC_IDX_W'(cmd.dev);
  assign volt_idx = on_db ? VOLT_IDX_W'(1 + int'(cmd.dev)) : '0;

  always_comb begin
    fail   = 1'b1;
    osc_we = 1'b0;
    rsrc   = RSRC_NONE;
    shut   = 1'b0;
    reboot = 1'b0;
    if (base_ok) begin
      case (cmd.func)
        FN_OSC: begin
          if (mb_osc_hit || db_osc_hit) begin
            fail = 1'b0;
            if (cmd.wr) osc_we = 1'b1;
            else        rsrc   = RSRC_OSC;
          end
        end
        FN_VOLT: begin
          if (!cmd.wr && ((on_mb && dev0) || db_volt_hit)) begin
            fail = 1'b0;
            rsrc = RSRC_VOLT;
          end
        end
        FN_MUX, FN_DISP: begin
          if (mb_only) fail = 1'b0;
        end
        FN_SHUT: begin
          if (mb_only) begin
            fail = 1'b0;
            shut = 1'b1;
          end
        end
        FN_REBOOT: begin
          if (mb_only) begin
            fail   = 1'b0;
            reboot = 1'b1;
          end
        end
        default: fail = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/cfg_osc_bank.sv
module cfg_osc_bank
  import cfg_txn_pkg::*;
#(
  parameter int                          DB_OSC_N    = 2,
  parameter logic [DB_OSC_N-1:0][31:0]   DB_OSC_INIT = {32'd45000000, 32'd30000000},
  parameter int                          IDX_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);

  localparam int TOTAL = MB_OSC_N + DB_OSC_N;

  logic [31:0] ent [TOTAL];

  for (genvar g = 0; g < TOTAL; g++) begin : g_ent
    logic [31:0] val_q;
    logic        hit;
    assign hit = we && (int'(idx) == g);
    if (g < MB_OSC_N) begin : g_mb
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   val_q <= mb_osc_reset(g);
        else if (hit) val_q <= wdata;
      end
    end else begin : g_db
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   val_q <= DB_OSC_INIT[g-MB_OSC_N];
        else if (hit) val_q <= wdata;
      end
    end
    assign ent[g] = val_q;
  end

  assign rdata = (int'(idx) < TOTAL) ? ent[idx] : '0;

endmodule

// File: rtl/cfg_volt_table.sv
module cfg_volt_table
  import cfg_txn_pkg::*;
#(
  parameter int                         DB_VOLT_N   = 3,
  parameter logic [DB_VOLT_N-1:0][31:0] DB_VOLT_VAL = {32'd1800000, 32'd1000000, 32'd900000},
  parameter int                         IDX_W       = 2
) (
  input  logic [IDX_W-1:0] idx,
  output logic [31:0]      val
);

  // entry 0 is the motherboard sensor, entries 1.. the daughterboard ones
  always_comb begin
    val = '0;
    if (idx == '0) val = MB_VOLT_UV;
    for (int i = 0; i < DB_VOLT_N; i++) begin
      if (int'(idx) == i + 1) val = DB_VOLT_VAL[i];
    end
  end

endmodule

// File: rtl/cfg_txn_engine.sv
module cfg_txn_engine
  import cfg_txn_pkg::*;
#(
  parameter int                         ADDR_W      = 8,
  parameter logic [11:0]                BOARD_ID    = 12'h190,
  parameter logic [ADDR_W-1:0]          DATA_OFS    = 'hA0,
  parameter logic [ADDR_W-1:0]          CTRL_OFS    = 'hA4,
  parameter logic [ADDR_W-1:0]          STAT_OFS    = 'hA8,
  parameter int                         DB_OSC_N    = 2,
  parameter logic [DB_OSC_N-1:0][31:0]  DB_OSC_INIT = {32'd45000000, 32'd30000000},
  parameter int                         DB_VOLT_N   = 3,
  parameter logic [DB_VOLT_N-1:0][31:0] DB_VOLT_VAL = {32'd1800000, 32'd1000000, 32'd900000}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       rd_data,
  output logic              shutdown_req,
  output logic              reboot_req
);

  localparam int  OSC_TOTAL  = MB_OSC_N + DB_OSC_N;
  localparam int  VOLT_TOTAL = 1 + DB_VOLT_N;
  localparam int  OSC_IDX_W  = (OSC_TOTAL > 1) ? $clog2(OSC_TOTAL) : 1;
  localparam int  VOLT_IDX_W = (VOLT_TOTAL > 1) ? $clog2(VOLT_TOTAL) : 1;
  localparam bit  PRESENT    = (BOARD_ID == 12'h190);

  logic                  regs_on;
  logic                  wr_data, wr_ctrl, wr_stat, launch;
  logic [31:0]           data_q, ctrl_q;
  logic [1:0]            stat_q;
  logic                  pend_q, shut_q, reboot_q;
  cmd_t                  cmd;
  logic                  fail, dec_osc_we, dec_shut, dec_reboot;
  rsrc_e                 rsrc;
  logic [OSC_IDX_W-1:0]  osc_idx;
  logic [VOLT_IDX_W-1:0] volt_idx;
  logic [31:0]           osc_rdata, volt_val, rd_result;
  logic                  txn_fire, txn_rd_ok, osc_we;

  assign regs_on = PRESENT;
  assign wr_data = regs_on && bus_wr && (bus_addr == DATA_OFS);
  assign wr_ctrl = regs_on && bus_wr && (bus_addr == CTRL_OFS);
  assign wr_stat = regs_on && bus_wr && (bus_addr == STAT_OFS);
  assign launch  = wr_ctrl && bus_wdata[31];

  assign cmd = cmd_t'(ctrl_q);

  cfg_cmd_decode #(
    .DB_OSC_N  (DB_OSC_N),
    .DB_VOLT_N (DB_VOLT_N),
    .OSC_IDX_W (OSC_IDX_W),
    .VOLT_IDX_W(VOLT_IDX_W)
  ) u_dec (
    .cmd     (cmd),
    .fail    (fail),
    .osc_we  (dec_osc_we),
    .rsrc    (rsrc),
    .osc_idx (osc_idx),
    .volt_idx(volt_idx),
    .shut    (dec_shut),
    .reboot  (dec_reboot)
  );

  // named transaction events
  assign txn_fire  = pend_q;
  assign txn_rd_ok = txn_fire && !fail && (rsrc != RSRC_NONE);
  assign osc_we    = txn_fire && !fail && dec_osc_we;

  cfg_osc_bank #(
    .DB_OSC_N   (DB_OSC_N),
    .DB_OSC_INIT(DB_OSC_INIT),
    .IDX_W      (OSC_IDX_W)
  ) u_osc (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (osc_we),
    .idx  (osc_idx),
    .wdata(data_q),
    .rdata(osc_rdata)
  );

  cfg_volt_table #(
    .DB_VOLT_N  (DB_VOLT_N),
    .DB_VOLT_VAL(DB_VOLT_VAL),
    .IDX_W      (VOLT_IDX_W)
  ) u_volt (
    .idx(volt_idx),
    .val(volt_val)
  );

  assign rd_result = (rsrc == RSRC_OSC) ? osc_rdata : volt_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q   <= '0;
      ctrl_q   <= '0;
      stat_q   <= '0;
      pend_q   <= 1'b0;
      shut_q   <= 1'b0;
      reboot_q <= 1'b0;
    end else begin
      pend_q   <= launch;
      shut_q   <= txn_fire && !fail && dec_shut;
      reboot_q <= txn_fire && !fail && dec_reboot;
      if (wr_ctrl) ctrl_q <= ctrl_keep(bus_wdata);
      // an executing command wins over a direct write in the same cycle
      if (txn_rd_ok)    data_q <= rd_result;
      else if (wr_data) data_q <= bus_wdata;
      if (txn_fire)     stat_q <= stat_word(fail);
      else if (wr_stat) stat_q <= bus_wdata[1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (regs_on) begin
      if (bus_addr == DATA_OFS)      rd_data = data_q;
      else if (bus_addr == CTRL_OFS) rd_data = ctrl_q;
      else if (bus_addr == STAT_OFS) rd_data = {30'd0, stat_q};
    end
  end

  assign shutdown_req = shut_q;
  assign reboot_req   = reboot_q;

endmodule

// File: rtl/cfg_txn_engine_chk.sv
module cfg_txn_engine_chk #(
  parameter int                ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'hA4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              regs_on,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       rd_data,
  input logic              txn_fire,
  input logic [31:0]       ctrl_q,
  input logic [1:0]        stat_q,
  input logic              shutdown_req,
  input logic              reboot_req
);

  // R3
  launch_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_on && bus_wr && bus_addr == CTRL_OFS && bus_wdata[31]) |=> txn_fire);

  // R3
  fire_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    txn_fire |=> stat_q[0]);

  // R4
  bad_ctl_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_fire && ctrl_q[29:26] != 4'd0) |=> stat_q[1]);

  // R2
  ctrl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == CTRL_OFS) |-> (rd_data[31] == 1'b0 && rd_data[19:18] == 2'b00));

  // R9
  shut_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> !shutdown_req);

  // R9
  reboot_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reboot_req |=> !reboot_req);

  // R9
  req_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shutdown_req || reboot_req) |-> $past(txn_fire));

  // R9
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shutdown_req, reboot_req}));

  // R12
  absent_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !regs_on |-> (rd_data == 32'd0 && !shutdown_req && !reboot_req));

endmodule

bind cfg_txn_engine cfg_txn_engine_chk #(
  .ADDR_W  (ADDR_W),
  .CTRL_OFS(CTRL_OFS)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .regs_on     (regs_on),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .rd_data     (rd_data),
  .txn_fire    (txn_fire),
  .ctrl_q      (ctrl_q),
  .stat_q      (stat_q),
  .shutdown_req(shutdown_req),
  .reboot_req  (reboot_req)
);

// File: tb/cfg_txn_engine_tb.sv
module cfg_txn_engine_tb;

  localparam logic [7:0] A_DATA = 8'hA0;
  localparam logic [7:0] A_CTRL = 8'hA4;
  localparam logic [7:0] A_STAT = 8'hA8;
  localparam int DBO = 2;
  localparam int DBV = 3;
  localparam logic [DBO-1:0][31:0] DB_OSC = {32'd45000000, 32'd30000000};
  localparam logic [DBV-1:0][31:0] DB_VLT = {32'd1800000, 32'd1000000, 32'd900000};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] rd_data, alt_rd;
  logic        shutdown_req, reboot_req, alt_shut, alt_reb;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [31:0] m_osc [8];
  logic [31:0] m_data;
  logic [1:0]  m_stat;
  logic        e_shut, e_reb;

  always #10 clk = ~clk;

  cfg_txn_engine #(.DB_OSC_N(DBO), .DB_OSC_INIT(DB_OSC), .DB_VOLT_N(DBV), .DB_VOLT_VAL(DB_VLT)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(rd_data), .shutdown_req(shutdown_req), .reboot_req(reboot_req));

  cfg_txn_engine #(.BOARD_ID(12'h178), .DB_OSC_N(DBO), .DB_OSC_INIT(DB_OSC), .DB_VOLT_N(DBV), .DB_VOLT_VAL(DB_VLT)) u_alt (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .rd_data(alt_rd), .shutdown_req(alt_shut), .reboot_req(alt_reb));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = rd_data;
  endtask

  function automatic logic [31:0] mk(input bit wr, input int dcc, input int fn,
                                     input int site, input int pos, input int dev);
    return {1'b0, wr, 4'(dcc), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
  endfunction

  // reference model: updates the model state and returns the requirement tag
  function automatic string model_run(input logic [31:0] w);
    bit wr = w[30];
    int dcc = int'(w[29:26]);
    int fn = int'(w[25:20]);
    int site = int'(w[17:16]);
    int pos = int'(w[15:12]);
    int dev = int'(w[11:0]);
    bit err = 1'b1;
    string tag = "R11";
    e_shut = 1'b0; e_reb = 1'b0;
    if (dcc != 0 || pos != 0 || site > 1) tag = "R4";
    else begin
      if (fn == 1) begin
        int lim = (site == 0) ? 6 : DBO;
        int idx = (site == 0) ? dev : 6 + dev;
        tag = (site == 0) ? "R5" : "R6";
        if (dev < lim) begin
          err = 1'b0;
          if (wr) m_osc[idx] = m_data;
          else    m_data = m_osc[idx];
        end
      end else if (fn == 2) begin
        tag = "R7";
        if (!wr && site == 0 && dev == 0) begin err = 1'b0; m_data = 32'd3300000; end
        else if (!wr && site == 1 && dev < DBV) begin err = 1'b0; m_data = DB_VLT[dev]; end
      end else if (fn == 7 || fn == 11 || fn == 8 || fn == 9) begin
        tag = (fn == 8 || fn == 9) ? "R9" : "R8";
        if (wr && site == 0 && dev == 0) begin
          err = 1'b0;
          e_shut = (fn == 8);
          e_reb  = (fn == 9);
        end
      end
    end
    m_stat = {err, 1'b1};
    return tag;
  endfunction

  task automatic run_cmd(input logic [31:0] w, input logic [31:0] dval);
    logic [31:0] v;
    logic [1:0] pre;
    string tag;
    bus_write(A_DATA, dval);
    m_data = dval;
    pre = m_stat;
    bus_write(A_CTRL, w | 32'h8000_0000);
    bus_read(A_STAT, v);
    chk("R3 status before execution", v, {30'd0, pre});
    chk("R9 no early shutdown", 32'(shutdown_req), 32'd0);
    tag = model_run(w);
    @(negedge clk);
    chk({tag, " R9 shutdown pulse"}, 32'(shutdown_req), 32'(e_shut));
    chk({tag, " R9 reboot pulse"}, 32'(reboot_req), 32'(e_reb));
    chk("R12 absent pulses", 32'(alt_shut | alt_reb), 32'd0);
    @(negedge clk);
    chk("R9 pulse ends", 32'(shutdown_req | reboot_req), 32'd0);
    bus_read(A_STAT, v);
    chk({tag, " status"}, v, {30'd0, m_stat});
    chk("R12 absent status", alt_rd, 32'd0);
    bus_read(A_DATA, v);
    chk({tag, " data"}, v, m_data);
    chk("R12 absent data", alt_rd, 32'd0);
    bus_read(A_CTRL, v);
    chk("R2 command readback", v, w & ~32'h800C_0000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 6; i++) m_osc[i] = (i == 0) ? 32'd50000000 : (i == 1) ? 32'd23750000 : 32'd24000000;
    m_osc[6] = DB_OSC[0]; m_osc[7] = DB_OSC[1];
    m_data = '0; m_stat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(A_DATA, v); chk("R1 data", v, 32'd0);
    bus_read(A_CTRL, v); chk("R1 ctrl", v, 32'd0);
    bus_read(A_STAT, v); chk("R1 stat", v, 32'd0);
    for (int d = 0; d < 6; d++) run_cmd(mk(0, 0, 1, 0, 0, d), 32'h0);
    run_cmd(mk(0, 0, 1, 0, 0, 1), 32'h0);
    bus_read(A_DATA, v); chk("R1 mb osc1", v, 32'd23750000);
    run_cmd(mk(0, 0, 1, 1, 0, 1), 32'h0);
    bus_read(A_DATA, v); chk("R1 db osc1", v, 32'd45000000);

    // R10 direct status writes
    bus_write(A_STAT, 32'hFFFF_FFFF); bus_read(A_STAT, v); chk("R10 stat all ones", v, 32'd3);
    bus_write(A_STAT, 32'h0000_0006); bus_read(A_STAT, v); chk("R10 stat 6", v, 32'd2);
    bus_write(A_STAT, 32'h0); m_stat = 2'd0;

    // R2/R3 command write without start runs nothing
    bus_write(A_CTRL, 32'h7FFF_FFFF);
    @(negedge clk); @(negedge clk);
    bus_read(A_CTRL, v); chk("R2 masked store", v, 32'h7FF3_FFFF);
    bus_read(A_STAT, v); chk("R3 no start no run", v, 32'd0);

    // R13 unmapped offsets
    bus_read(8'h00, v); chk("R13 offset 00", v, 32'd0);
    bus_read(8'hAC, v); chk("R13 offset AC", v, 32'd0);

    // R5 / R6 oscillator writes and bounds
    run_cmd(mk(1, 0, 1, 0, 0, 3), 32'h0012_3456);
    run_cmd(mk(0, 0, 1, 0, 0, 3), 32'h0);
    run_cmd(mk(0, 0, 1, 0, 0, 6), 32'hAAAA_5555);
    run_cmd(mk(1, 0, 1, 1, 0, 1), 32'h0BAD_CAFE);
    run_cmd(mk(0, 0, 1, 1, 0, 1), 32'h0);
    run_cmd(mk(0, 0, 1, 1, 0, 2), 32'h1111_2222);
    // R7 voltages
    run_cmd(mk(0, 0, 2, 0, 0, 0), 32'h0);
    run_cmd(mk(0, 0, 2, 0, 0, 1), 32'h5);
    for (int d = 0; d < 4; d++) run_cmd(mk(0, 0, 2, 1, 0, d), 32'h7);
    run_cmd(mk(1, 0, 2, 0, 0, 0), 32'h9);
    // R8 accepted no-ops
    run_cmd(mk(1, 0, 7, 0, 0, 0), 32'hDEAD_BEEF);
    run_cmd(mk(1, 0, 11, 0, 0, 0), 32'h1234_0000);
    run_cmd(mk(1, 0, 7, 1, 0, 0), 32'h1);
    run_cmd(mk(0, 0, 11, 0, 0, 0), 32'h2);
    run_cmd(mk(0, 0, 1, 0, 0, 0), 32'h0);
    bus_read(A_DATA, v); chk("R8 osc untouched", v, 32'd50000000);
    // R9 requests
    run_cmd(mk(1, 0, 8, 0, 0, 0), 32'h0);
    run_cmd(mk(1, 0, 9, 0, 0, 0), 32'h0);
    run_cmd(mk(0, 0, 8, 0, 0, 0), 32'h0);
    run_cmd(mk(1, 0, 9, 0, 0, 1), 32'h0);
    // R4 unsupported addressing, R11 unknown function
    run_cmd(mk(0, 1, 1, 0, 0, 0), 32'h3);
    run_cmd(mk(0, 0, 1, 0, 1, 0), 32'h3);
    run_cmd(mk(0, 0, 1, 2, 0, 0), 32'h3);
    run_cmd(mk(1, 0, 1, 3, 0, 0), 32'h3);
    run_cmd(mk(1, 0, 5, 0, 0, 0), 32'h3);

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      int fns [10] = '{1, 1, 1, 2, 2, 7, 8, 9, 11, 0};
      int fn   = fns[$urandom % 10];
      int dcc  = ($urandom % 8 == 0) ? int'($urandom % 16) : 0;
      int pos  = ($urandom % 8 == 0) ? int'($urandom % 16) : 0;
      int site = ($urandom % 5 == 0) ? int'($urandom % 4) : int'($urandom % 2);
      int dev  = int'($urandom % 8);
      logic [31:0] w;
      if (fn == 0) fn = int'($urandom % 64);
      w = mk($urandom % 2 == 1, dcc, fn, site, pos, dev);
      w[19:18] = 2'($urandom);
      run_cmd(w, $urandom);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule